// File: doc/BRIEF.md
# Dual-Sided Inter-Processor Message Unit

This block links two processors, called side A and side B, through two independent 32-bit register ports that share one clock. Each side has four channels. A word one side writes into its transmit slot n shows up in the receive slot n of the opposite side. A full/empty handshake tracks every slot so that neither processor needs to poll shared memory. Each side also has four doorbells. Setting a request bit on one side raises a pending flag on the other side, and the receiving processor acknowledges it with a write-one-to-clear.

Each side has one level interrupt. It is raised whenever any of that side's status flags is set and the matching enable in that side's control word is set. The status and control words place the per-channel bits in reversed order inside fixed nibbles. Channel 0 therefore occupies the most significant bit of each nibble.

The register map of each side, by byte offset, is:
- 0x00, 0x04, 0x08, 0x0C: transmit slots 0 to 3.
- 0x10, 0x14, 0x18, 0x1C: receive slots 0 to 3.
- 0x20: status word.
- 0x24: control word.

Accesses are single-cycle. Read data is combinational from the current state, and read side effects take place at the clock edge that ends the access.

Top module: `msg_unit`

## Requirements
- R1: A word written to transmit slot n (offset 4n) on one side is returned by a read of receive slot n (offset 0x10+4n) on the other side.
- R2: In the status word (offset 0x20), channel n has its doorbell-pending flag at bit 28+(3-n), its receive-full flag at bit 24+(3-n) and its transmit-empty flag at bit 20+(3-n).
- R3: Writing transmit slot n on one side clears that side's transmit-empty flag n and sets the other side's receive-full flag n at the same clock edge.
- R4: Reading receive slot n clears that side's receive-full flag n and sets the other side's transmit-empty flag n again.
- R5: After reset both status words read 0x00F00000 (all transmit-empty set, all other flags clear), both control words read 0 and both interrupts are low.
- R6: A side's interrupt is high exactly when some status flag and the enable at the same bit position of that side's control word (offset 0x24) are both set.
- R7: Writing a one to control bit 16+(3-n) sets the request bit and raises doorbell-pending flag n on the other side. Writing a zero there does not clear the request bit.
- R8: Writing a one to a doorbell-pending bit of the status word clears it. Writing zero to it has no effect.
- R9: A request bit clears itself at the clock edge after the other side's pending flag for that channel has been cleared.
- R10: When one side writes transmit slot n in the same cycle as the other side reads receive slot n, the read returns the old word, the receive-full flag stays set and the new word is stored.
- R11: Reserved bits read as zero and ignore writes (status bits 19:0, control bits 15:0). Transmit slots and unmapped offsets read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock |
| rst | input | 1 | Synchronous active-high reset |
| a_wr_en | input | 1 | Side A write strobe |
| a_rd_en | input | 1 | Side A read strobe |
| a_addr | input | 6 | Side A byte offset |
| a_wdata | input | 32 | Side A write data |
| a_rdata | output | 32 | Side A read data |
| a_irq | output | 1 | Side A level interrupt |
| b_wr_en | input | 1 | Side B write strobe |
| b_rd_en | input | 1 | Side B read strobe |
| b_addr | input | 6 | Side B byte offset |
| b_wdata | input | 32 | Side B write data |
| b_rdata | output | 32 | Side B read data |
| b_irq | output | 1 | Side B level interrupt |

## Verification
Two functions can fall on the same edge:
- a transmit write on one side and a receive read of the same channel on the other;
- a doorbell acknowledge on one side while the request bit on the other side is waiting to clear.

The bench drives both ports in one cycle, with side A writing slot 1 while side B reads it. It judges the result by three things: the word returned (the old word), the receive-full flag after the edge (still set), and the word then held in the slot (the new word). For the doorbell, the request bit is read in the cycle right after the acknowledge and again one cycle later. This confirms that it falls exactly one edge after the pending flag.

// File: rtl/mu_pkg.sv
package mu_pkg;

    localparam int NCH = 4;
    localparam int DW  = 32;
    localparam int AW  = 6;

    localparam logic [AW-1:0] OFS_TX   = AW'(0);
    localparam logic [AW-1:0] OFS_RX   = AW'(16);
    localparam logic [AW-1:0] OFS_STAT = AW'(32);
    localparam logic [AW-1:0] OFS_CTRL = AW'(36);

    localparam int POS_GIP = 28;
    localparam int POS_RF  = 24;
    localparam int POS_TE  = 20;
    localparam int POS_REQ = 16;

    localparam logic [DW-1:0] EN_MASK = DW'(32'hFFF0_0000);

    typedef struct packed {
        logic          wr;
        logic          rd;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
    } bus_req_t;

    typedef struct packed {
        logic [NCH-1:0] gip;
        logic [NCH-1:0] rf;
        logic [NCH-1:0] te;
    } flags_t;

    function automatic int bitpos(input int base, input int ch);
        return base + (NCH - 1 - ch);
    endfunction

    function automatic logic [AW-1:0] slot_ofs(input logic [AW-1:0] base, input int ch);
        return base + AW'(4 * ch);
    endfunction

endpackage

// File: rtl/mu_lane.sv
module mu_lane
    import mu_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    input  logic          ring_set,
    input  logic          ring_clr,
    output logic [DW-1:0] slot_data,
    output logic          slot_full,
    output logic          ring_pend
);

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_data <= '0;
            slot_full <= 1'b0;
            ring_pend <= 1'b0;
        end else begin
            if (push) begin
                slot_data <= push_data;
            end
            if (push) begin
                slot_full <= 1'b1;
            end else if (pop) begin
                slot_full <= 1'b0;
            end
            if (ring_set) begin
                ring_pend <= 1'b1;
            end else if (ring_clr) begin
                ring_pend <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/mu_port.sv
module mu_port
    import mu_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  bus_req_t                req,
    input  flags_t                  flg,
    input  logic [NCH-1:0][DW-1:0]  rx_data,
    input  logic [NCH-1:0]          peer_gip,
    output logic [NCH-1:0]          tx_wr,
    output logic [NCH-1:0]          rx_rd,
    output logic [NCH-1:0]          gip_clr,
    output logic [NCH-1:0]          req_set,
    output logic [NCH-1:0]          req_bits,
    output logic [DW-1:0]           rdata,
    output logic                    irq
);

    logic          stat_wr;
    logic          ctrl_wr;
    logic [DW-1:0] en_nxt;
    logic [DW-1:0] en_q;
    logic [DW-1:0] stat_word;
    logic [DW-1:0] ctrl_word;

    assign stat_wr = req.wr && (req.addr == OFS_STAT);
    assign ctrl_wr = req.wr && (req.addr == OFS_CTRL);
    assign en_nxt  = req.wdata & EN_MASK;

    for (genvar n = 0; n < NCH; n++) begin : g_dec
        assign tx_wr[n]   = req.wr && (req.addr == slot_ofs(OFS_TX, n));
        assign rx_rd[n]   = req.rd && (req.addr == slot_ofs(OFS_RX, n));
        assign gip_clr[n] = stat_wr && req.wdata[bitpos(POS_GIP, n)];
        assign req_set[n] = ctrl_wr && req.wdata[bitpos(POS_REQ, n)] && !req_bits[n];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= '0;
        end else if (ctrl_wr) begin
            en_q <= en_nxt;
        end
    end

    always_ff @(posedge clk) begin
        for (int n = 0; n < NCH; n++) begin
            if (rst) begin
                req_bits[n] <= 1'b0;
            end else if (req_set[n]) begin
                req_bits[n] <= 1'b1;
            end else if (!peer_gip[n]) begin
                req_bits[n] <= 1'b0;
            end
        end
    end

    always_comb begin
        stat_word = '0;
        ctrl_word = en_q;
        for (int n = 0; n < NCH; n++) begin
            stat_word[bitpos(POS_GIP, n)] = flg.gip[n];
            stat_word[bitpos(POS_RF, n)]  = flg.rf[n];
            stat_word[bitpos(POS_TE, n)]  = flg.te[n];
            ctrl_word[bitpos(POS_REQ, n)] = req_bits[n];
        end
    end

    always_comb begin
        rdata = '0;
        for (int n = 0; n < NCH; n++) begin
            if (req.addr == slot_ofs(OFS_RX, n)) begin
                rdata = rx_data[n];
            end
        end
        if (req.addr == OFS_STAT) begin
            rdata = stat_word;
        end
        if (req.addr == OFS_CTRL) begin
            rdata = ctrl_word;
        end
    end

    assign irq = |(stat_word & en_q);

endmodule

// File: rtl/msg_unit.sv
module msg_unit
    import mu_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          a_wr_en,
    input  logic          a_rd_en,
    input  logic [5:0]    a_addr,
    input  logic [31:0]   a_wdata,
    output logic [31:0]   a_rdata,
    output logic          a_irq,
    input  logic          b_wr_en,
    input  logic          b_rd_en,
    input  logic [5:0]    b_addr,
    input  logic [31:0]   b_wdata,
    output logic [31:0]   b_rdata,
    output logic          b_irq
);

    bus_req_t               a_req, b_req;
    flags_t                 a_flg, b_flg;
    logic [NCH-1:0][DW-1:0] a_rx_data, b_rx_data;
    logic [NCH-1:0]         rf_a, rf_b, gip_a, gip_b, gir_a, gir_b;
    logic [NCH-1:0]         a_tx_wr, a_rx_rd, a_gip_clr, a_req_set;
    logic [NCH-1:0]         b_tx_wr, b_rx_rd, b_gip_clr, b_req_set;

    assign a_req = '{wr: a_wr_en, rd: a_rd_en, addr: a_addr, wdata: a_wdata};
    assign b_req = '{wr: b_wr_en, rd: b_rd_en, addr: b_addr, wdata: b_wdata};

    assign a_flg = '{gip: gip_a, rf: rf_a, te: ~rf_b};
    assign b_flg = '{gip: gip_b, rf: rf_b, te: ~rf_a};

    mu_port u_port_a (
        .clk      (clk),
        .rst      (rst),
        .req      (a_req),
        .flg      (a_flg),
        .rx_data  (a_rx_data),
        .peer_gip (gip_b),
        .tx_wr    (a_tx_wr),
        .rx_rd    (a_rx_rd),
        .gip_clr  (a_gip_clr),
        .req_set  (a_req_set),
        .req_bits (gir_a),
        .rdata    (a_rdata),
        .irq      (a_irq)
    );

    mu_port u_port_b (
        .clk      (clk),
        .rst      (rst),
        .req      (b_req),
        .flg      (b_flg),
        .rx_data  (b_rx_data),
        .peer_gip (gip_a),
        .tx_wr    (b_tx_wr),
        .rx_rd    (b_rx_rd),
        .gip_clr  (b_gip_clr),
        .req_set  (b_req_set),
        .req_bits (gir_b),
        .rdata    (b_rdata),
        .irq      (b_irq)
    );

    for (genvar n = 0; n < NCH; n++) begin : g_ch
        mu_lane u_a_to_b (
            .clk       (clk),
            .rst       (rst),
            .push      (a_tx_wr[n]),
            .push_data (a_wdata),
            .pop       (b_rx_rd[n]),
            .ring_set  (a_req_set[n]),
            .ring_clr  (b_gip_clr[n]),
            .slot_data (b_rx_data[n]),
            .slot_full (rf_b[n]),
            .ring_pend (gip_b[n])
        );
        mu_lane u_b_to_a (
            .clk       (clk),
            .rst       (rst),
            .push      (b_tx_wr[n]),
            .push_data (b_wdata),
            .pop       (a_rx_rd[n]),
            .ring_set  (b_req_set[n]),
            .ring_clr  (a_gip_clr[n]),
            .slot_data (a_rx_data[n]),
            .slot_full (rf_a[n]),
            .ring_pend (gip_a[n])
        );
    end

endmodule

// File: rtl/mu_chk.sv
module mu_chk
    import mu_pkg::*;
(
    input logic           clk,
    input logic           rst,
    input logic           a_wr_en,
    input logic           a_rd_en,
    input logic [AW-1:0]  a_addr,
    input logic [DW-1:0]  a_wdata,
    input logic           b_wr_en,
    input logic           b_rd_en,
    input logic [AW-1:0]  b_addr,
    input logic [DW-1:0]  b_wdata,
    input logic           a_irq,
    input logic           b_irq,
    input logic [NCH-1:0] rf_a,
    input logic [NCH-1:0] rf_b,
    input logic [NCH-1:0] gip_a,
    input logic [NCH-1:0] gip_b,
    input logic [NCH-1:0] gir_a,
    input logic [NCH-1:0] gir_b
);

    assert_reset_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!a_irq && !b_irq && rf_a == '0 && rf_b == '0));

    assert_irq_a_source_R6: assert property (@(posedge clk) disable iff (rst)
        a_irq |-> ((rf_a | gip_a | ~rf_b) != '0));

    assert_irq_b_source_R6: assert property (@(posedge clk) disable iff (rst)
        b_irq |-> ((rf_b | gip_b | ~rf_a) != '0));

    for (genvar n = 0; n < NCH; n++) begin : g_chk
        assert_push_ab_R3: assert property (@(posedge clk) disable iff (rst)
            (a_wr_en && a_addr == AW'(4 * n)) |=> rf_b[n]);

        assert_push_ba_R3: assert property (@(posedge clk) disable iff (rst)
            (b_wr_en && b_addr == AW'(4 * n)) |=> rf_a[n]);

        assert_pop_b_R4: assert property (@(posedge clk) disable iff (rst)
            (b_rd_en && b_addr == AW'(16 + 4 * n) && !(a_wr_en && a_addr == AW'(4 * n)))
            |=> !rf_b[n]);

        assert_pop_a_R4: assert property (@(posedge clk) disable iff (rst)
            (a_rd_en && a_addr == AW'(16 + 4 * n) && !(b_wr_en && b_addr == AW'(4 * n)))
            |=> !rf_a[n]);

        assert_collide_write_wins_R10: assert property (@(posedge clk) disable iff (rst)
            (a_wr_en && a_addr == AW'(4 * n) && b_rd_en && b_addr == AW'(16 + 4 * n))
            |=> rf_b[n]);

        assert_ring_raises_R7: assert property (@(posedge clk) disable iff (rst)
            (a_wr_en && a_addr == AW'(36) && a_wdata[bitpos(POS_REQ, n)] && !gir_a[n])
            |=> (gip_b[n] && gir_a[n]));

        assert_ack_clears_R8: assert property (@(posedge clk) disable iff (rst)
            (b_wr_en && b_addr == AW'(32) && b_wdata[bitpos(POS_GIP, n)]
             && !(a_wr_en && a_addr == AW'(36) && a_wdata[bitpos(POS_REQ, n)]))
            |=> !gip_b[n]);

        assert_req_a_selfclear_R9: assert property (@(posedge clk) disable iff (rst)
            (gir_a[n] && !gip_b[n]) |=> !gir_a[n]);

        assert_req_b_selfclear_R9: assert property (@(posedge clk) disable iff (rst)
            (gir_b[n] && !gip_a[n]) |=> !gir_b[n]);
    end

endmodule

bind msg_unit mu_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .a_wr_en (a_wr_en),
    .a_rd_en (a_rd_en),
    .a_addr  (a_addr),
    .a_wdata (a_wdata),
    .b_wr_en (b_wr_en),
    .b_rd_en (b_rd_en),
    .b_addr  (b_addr),
    .b_wdata (b_wdata),
    .a_irq   (a_irq),
    .b_irq   (b_irq),
    .rf_a    (rf_a),
    .rf_b    (rf_b),
    .gip_a   (gip_a),
    .gip_b   (gip_b),
    .gir_a   (gir_a),
    .gir_b   (gir_b)
);

// File: tb/msg_unit_tb.sv
module msg_unit_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 15;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        a_wr_en = 1'b0, a_rd_en = 1'b0;
    logic [5:0]  a_addr = '0;
    logic [31:0] a_wdata = '0;
    logic [31:0] a_rdata;
    logic        a_irq;
    logic        b_wr_en = 1'b0, b_rd_en = 1'b0;
    logic [5:0]  b_addr = '0;
    logic [31:0] b_wdata = '0;
    logic [31:0] b_rdata;
    logic        b_irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    msg_unit u_dut (
        .clk     (clk),
        .rst     (rst),
        .a_wr_en (a_wr_en),
        .a_rd_en (a_rd_en),
        .a_addr  (a_addr),
        .a_wdata (a_wdata),
        .a_rdata (a_rdata),
        .a_irq   (a_irq),
        .b_wr_en (b_wr_en),
        .b_rd_en (b_rd_en),
        .b_addr  (b_addr),
        .b_wdata (b_wdata),
        .b_rdata (b_rdata),
        .b_irq   (b_irq)
    );

    // Row: {tag[3:0], side, is_write, addr[5:0], data_or_expect[31:0]}
    localparam logic [43:0] VEC [NV] = '{
        {4'd5,  1'b0, 1'b0, 6'h20, 32'h00F0_0000},  // R5 side A status
        {4'd5,  1'b1, 1'b0, 6'h20, 32'h00F0_0000},  // R5 side B status
        {4'd5,  1'b0, 1'b0, 6'h24, 32'h0000_0000},  // R5 side A control
        {4'd1,  1'b0, 1'b1, 6'h00, 32'hDEAD_BEEF},  // R1 A sends on slot 0
        {4'd3,  1'b0, 1'b0, 6'h20, 32'h0070_0000},  // R3 A empty flag 0 (bit 23) cleared
        {4'd3,  1'b1, 1'b0, 6'h20, 32'h08F0_0000},  // R3 B full flag 0 (bit 27) set
        {4'd1,  1'b1, 1'b0, 6'h10, 32'hDEAD_BEEF},  // R1 B reads slot 0
        {4'd4,  1'b1, 1'b0, 6'h20, 32'h00F0_0000},  // R4 B full flag cleared
        {4'd4,  1'b0, 1'b0, 6'h20, 32'h00F0_0000},  // R4 A empty flag back
        {4'd1,  1'b1, 1'b1, 6'h0C, 32'h1234_5678},  // R1 B sends on slot 3
        {4'd2,  1'b0, 1'b0, 6'h20, 32'h01F0_0000},  // R2 A full flag 3 at bit 24
        {4'd2,  1'b1, 1'b0, 6'h20, 32'h00E0_0000},  // R2 B empty flag 3 at bit 20
        {4'd1,  1'b0, 1'b0, 6'h1C, 32'h1234_5678},  // R1 A reads slot 3
        {4'd11, 1'b0, 1'b0, 6'h00, 32'h0000_0000},  // R11 transmit slot reads zero
        {4'd11, 1'b0, 1'b0, 6'h28, 32'h0000_0000}   // R11 unmapped offset reads zero
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input bit side, input logic [5:0] ad, input logic [31:0] d);
        if (!side) begin
            a_wr_en = 1'b1; a_addr = ad; a_wdata = d;
        end else begin
            b_wr_en = 1'b1; b_addr = ad; b_wdata = d;
        end
        @(negedge clk);
        a_wr_en = 1'b0;
        b_wr_en = 1'b0;
    endtask

    task automatic bus_rd(input bit side, input logic [5:0] ad, output logic [31:0] q);
        if (!side) begin
            a_rd_en = 1'b1; a_addr = ad;
        end else begin
            b_rd_en = 1'b1; b_addr = ad;
        end
        #1;
        q = side ? b_rdata : a_rdata;
        @(negedge clk);
        a_rd_en = 1'b0;
        b_rd_en = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        logic [31:0] q;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        check("R5 a_irq", {31'd0, a_irq}, 32'd0);
        check("R5 b_irq", {31'd0, b_irq}, 32'd0);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][38]) begin
                bus_wr(VEC[i][39], VEC[i][37:32], VEC[i][31:0]);
            end else begin
                bus_rd(VEC[i][39], VEC[i][37:32], q);
                check($sformatf("R%0d row %0d", VEC[i][43:40], i), q, VEC[i][31:0]);
            end
        end

        // R6: empty interrupt on A, bit 23
        bus_wr(0, 6'h24, 32'h0080_0000);
        check("R6 empty irq high", {31'd0, a_irq}, 32'd1);
        check("R6 other side quiet", {31'd0, b_irq}, 32'd0);
        bus_wr(0, 6'h00, 32'h0000_00A5);
        check("R6 empty irq drops", {31'd0, a_irq}, 32'd0);
        bus_wr(0, 6'h24, 32'h0);
        bus_rd(1, 6'h10, q);
        // R6: full interrupt on B, bit 27
        bus_wr(1, 6'h24, 32'h0800_0000);
        check("R6 full irq idle", {31'd0, b_irq}, 32'd0);
        bus_wr(0, 6'h00, 32'h0000_0001);
        check("R6 full irq high", {31'd0, b_irq}, 32'd1);
        bus_rd(1, 6'h10, q);
        check("R6 full irq drops", {31'd0, b_irq}, 32'd0);
        bus_wr(1, 6'h24, 32'h0);

        // R11: reserved bits
        bus_wr(0, 6'h24, 32'h0000_FFFF);
        bus_rd(0, 6'h24, q);
        check("R11 control reserved", q, 32'h0);
        bus_wr(0, 6'h20, 32'h00FF_FFFF);
        bus_rd(0, 6'h20, q);
        check("R11 status reserved", q, 32'h00F0_0000);

        // R7: doorbell on channel 0 (request bit 19, pending bit 31)
        bus_wr(0, 6'h24, 32'h0008_0000);
        bus_rd(1, 6'h20, q);
        check("R7 peer pending", q, 32'h80F0_0000);
        bus_wr(0, 6'h24, 32'h0);
        bus_rd(0, 6'h24, q);
        check("R7 zero keeps request", q, 32'h0008_0000);
        bus_wr(1, 6'h24, 32'h8000_0000);
        check("R6 doorbell irq", {31'd0, b_irq}, 32'd1);

        // R8: write-one-to-clear
        bus_wr(1, 6'h20, 32'h7FFF_FFFF);
        bus_rd(1, 6'h20, q);
        check("R8 zero no effect", q, 32'h80F0_0000);
        bus_wr(1, 6'h20, 32'h8000_0000);
        // R9: request still set one cycle, gone the next
        bus_rd(0, 6'h24, q);
        check("R9 request lingers", q, 32'h0008_0000);
        bus_rd(0, 6'h24, q);
        check("R9 request cleared", q, 32'h0);
        bus_rd(1, 6'h20, q);
        check("R8 pending cleared", q, 32'h00F0_0000);
        check("R8 irq released", {31'd0, b_irq}, 32'd0);
        bus_wr(1, 6'h24, 32'h0);

        // R10: A writes slot 1 while B reads slot 1
        bus_wr(0, 6'h04, 32'h1111_1111);
        a_wr_en = 1'b1; a_addr = 6'h04; a_wdata = 32'h2222_2222;
        b_rd_en = 1'b1; b_addr = 6'h14;
        #1;
        check("R10 read returns old", b_rdata, 32'h1111_1111);
        @(negedge clk);
        a_wr_en = 1'b0;
        b_rd_en = 1'b0;
        bus_rd(1, 6'h20, q);
        check("R10 full stays set", q, 32'h04F0_0000);
        bus_rd(0, 6'h20, q);
        check("R10 sender not empty", q, 32'h00B0_0000);
        bus_rd(1, 6'h14, q);
        check("R10 new word stored", q, 32'h2222_2222);

        finish_run();
    end

endmodule